// File: doc/BRIEF.md
# Wiper Position Counter with Bus-Clocked Stepping

This block keeps the 6-bit volatile position of one potentiometer channel's wiper. It turns that position into a registered, one-hot select across 64 tap switches. The position can change in four ways:

- It is recalled from data register entry 0 after power-up.
- It is loaded in parallel from any of the channel's four data register entries.
- It is written directly with a value the host sent.
- It is stepped by one position at a time.

The surrounding bus front end decodes commands. It passes this block one-cycle request pulses, together with the sampled serial clock and data lines.

Once an increment/decrement command has been acknowledged, the serial clock line acts as the count clock and the serial data line gives the direction. Every complete high pulse of the clock moves the wiper one tap. The data level held during the pulse picks the direction: high moves toward the top tap and low moves toward the bottom tap. This goes on for any number of pulses until a stop condition ends the mode. The scl and sda inputs are expected to be synchronous to clk already, because the bus front end synchronises them.

Top module: `wiper_step_counter`

## Requirements
- R1: Position value v drives tap_sel bit v and no other bit, so value 0x00 selects the bottom tap (bit 0) and 0x3F selects the top tap (bit 63).
- R2: tap_sel is registered. It shows a new position in the cycle after wiper_pos changes.
- R3: While stepping is active, a clock high pulse with sda held high raises wiper_pos by one, and one with sda held low lowers it by one. The change appears in the cycle where the falling edge of scl is sampled.
- R4: A one-cycle step_arm pulse starts stepping. Stepping lasts for any number of pulses and ends when a stop condition (sda rising while scl stays high) is seen. Clock pulses while stepping is inactive leave wiper_pos unchanged.
- R5: recall_go loads entry 0 of dreg_bank, which is bits 5:0.
- R6: xfer_go loads the entry of dreg_bank picked by xfer_sel. Entry i sits at bits 6i+5 down to 6i.
- R7: wr_go loads wr_val.
- R8: Stepping saturates: an up step at 0x3F leaves 0x3F, and a down step at 0x00 leaves 0x00.
- R9: At most one source changes the position per cycle. The order, highest first, is recall_go, then xfer_go, then wr_go, then a step.
- R10: Synchronous reset sets wiper_pos to 0, tap_sel to bit 0 only, and step_active to 0.
- R11: A clock high pulse during which sda changes does not step the wiper.
- R12: step_active is high from the cycle after step_arm until the cycle after the stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| dreg_bank | input | 24 | Four 6-bit data register entries, entry i at bits 6i+5:6i |
| recall_go | input | 1 | Power-up recall request, loads entry 0 |
| xfer_go | input | 1 | Parallel transfer request |
| xfer_sel | input | 2 | Entry picked for the parallel transfer |
| wr_go | input | 1 | Host direct write request |
| wr_val | input | 6 | Position value sent by the host |
| step_arm | input | 1 | Pulse when an increment/decrement command is acknowledged |
| scl | input | 1 | Sampled serial clock line |
| sda | input | 1 | Sampled serial data line |
| wiper_pos | output | 6 | Current wiper position |
| tap_sel | output | 64 | Registered one-hot tap select |
| step_active | output | 1 | Stepping mode is active |

## Verification
Directed pulse trains are used in several ways:

- Runs of all-high pulses and all-low pulses, carried up to each end, separate plain counting from saturation and from wrap-around.
- Pulses given before arming and after a stop show whether the mode boundary is kept.
- A pulse in which sda moves checks that only clean pulses count.
- Coincident requests of every pair show the priority order.

Seeded random sessions then mix transfers, writes and up and down pulses. These catch interactions between loading and stepping that the directed cases miss. After every operation, the tap select is compared one cycle later against a decode computed in the bench.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    localparam int POS_W  = 6;
    localparam int TAPS   = 1 << POS_W;
    localparam int NBANK  = 4;
    localparam int SEL_W  = $clog2(NBANK);
    localparam int BANK_W = NBANK * POS_W;

    typedef logic [POS_W-1:0] pos_t;
    typedef logic [TAPS-1:0]  tap_t;

    localparam pos_t POS_MAX = '1;
    localparam pos_t POS_MIN = '0;

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_RECALL,
        SRC_XFER,
        SRC_WRITE,
        SRC_STEP
    } src_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic stop;
        logic sda_moved;
    } bus_ev_t;

    function automatic pos_t sat_step(pos_t p, logic up);
        pos_t r;
        if (up) r = (p == POS_MAX) ? p : p + pos_t'(1);
        else    r = (p == POS_MIN) ? p : p - pos_t'(1);
        return r;
    endfunction

    function automatic tap_t tap_decode(pos_t p);
        tap_t t;
        t    = '0;
        t[p] = 1'b1;
        return t;
    endfunction

endpackage

// File: rtl/wsc_bus_events.sv
module wsc_bus_events
    import wsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);
    logic scl_q;
    logic sda_q;

    // Idle bus lines rest high.
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        ev.rise      = scl & ~scl_q;
        ev.fall      = ~scl & scl_q;
        ev.stop      = scl & scl_q & sda & ~sda_q;
        ev.sda_moved = scl & scl_q & (sda != sda_q);
    end

endmodule

// File: rtl/wsc_step_ctl.sv
module wsc_step_ctl
    import wsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    step_arm,
    input  logic    sda,
    input  bus_ev_t ev,
    output logic    mode_q,
    output logic    step_req,
    output logic    step_up
);
    logic dir_q;
    logic clean_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= 1'b0;
            dir_q   <= 1'b0;
            clean_q <= 1'b0;
        end else begin
            if (step_arm)     mode_q <= 1'b1;
            else if (ev.stop) mode_q <= 1'b0;

            if (ev.rise) begin
                dir_q   <= sda;
                clean_q <= 1'b1;
            end else if (ev.sda_moved) begin
                clean_q <= 1'b0;
            end
        end
    end

    // A pulse counts at its falling edge, only if sda held still throughout.
    assign step_req = mode_q & ev.fall & clean_q;
    assign step_up  = dir_q;

    // R4 / R12: stop ends stepping
    assert_stop_ends_mode_R4: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && !step_arm) |=> !mode_q);

    // R12: arming starts stepping
    assert_arm_starts_mode_R12: assert property (@(posedge clk) disable iff (rst)
        step_arm |=> mode_q);

    // R11: a pulse with a moving data line never yields a step at its end
    assert_dirty_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        (ev.sda_moved && !ev.rise) |=> !(step_req && !ev.rise && $past(ev.sda_moved) && ev.fall));

endmodule

// File: rtl/wsc_pos_arb.sv
module wsc_pos_arb
    import wsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] dreg_bank,
    input  logic              recall_go,
    input  logic              xfer_go,
    input  logic [SEL_W-1:0]  xfer_sel,
    input  logic              wr_go,
    input  pos_t              wr_val,
    input  logic              step_req,
    input  logic              step_up,
    output pos_t              pos_q
);
    pos_t bank_arr [NBANK];
    src_e src;
    pos_t pos_d;
    logic any_load;

    for (genvar i = 0; i < NBANK; i++) begin : g_unpack
        assign bank_arr[i] = dreg_bank[i*POS_W +: POS_W];
    end

    assign any_load = recall_go | xfer_go | wr_go;

    always_comb begin
        if (recall_go)     src = SRC_RECALL;
        else if (xfer_go)  src = SRC_XFER;
        else if (wr_go)    src = SRC_WRITE;
        else if (step_req) src = SRC_STEP;
        else               src = SRC_HOLD;
    end

    always_comb begin
        unique case (src)
            SRC_RECALL: pos_d = bank_arr[0];
            SRC_XFER:   pos_d = bank_arr[xfer_sel];
            SRC_WRITE:  pos_d = wr_val;
            SRC_STEP:   pos_d = sat_step(pos_q, step_up);
            default:    pos_d = pos_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pos_q <= POS_MIN;
        else     pos_q <= pos_d;
    end

    // R5 / R9: recall outranks everything
    assert_recall_load_R5: assert property (@(posedge clk) disable iff (rst)
        recall_go |=> (pos_q == $past(bank_arr[0])));

    // R6 / R9: transfer outranks host write and step
    assert_xfer_prio_R9: assert property (@(posedge clk) disable iff (rst)
        (xfer_go && !recall_go) |=> (pos_q == $past(bank_arr[xfer_sel])));

    // R7: host write when no higher source
    assert_write_load_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_go && !recall_go && !xfer_go) |=> (pos_q == $past(wr_val)));

    // R8: saturation at both ends
    assert_sat_top_R8: assert property (@(posedge clk) disable iff (rst)
        (step_req && step_up && !any_load && pos_q == POS_MAX) |=> (pos_q == POS_MAX));
    assert_sat_bottom_R8: assert property (@(posedge clk) disable iff (rst)
        (step_req && !step_up && !any_load && pos_q == POS_MIN) |=> (pos_q == POS_MIN));

    // R3: single step moves exactly one position
    assert_step_up_R3: assert property (@(posedge clk) disable iff (rst)
        (step_req && step_up && !any_load && pos_q != POS_MAX) |=> (pos_q == $past(pos_q) + pos_t'(1)));

    // R4: with no request the position holds
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!step_req && !any_load) |=> $stable(pos_q));

endmodule

// File: rtl/wsc_tap_decode.sv
module wsc_tap_decode
    import wsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pos_t pos_in,
    output tap_t tap_q
);
    localparam tap_t TAP_ONE = tap_t'(1);

    always_ff @(posedge clk) begin
        if (rst) tap_q <= TAP_ONE;
        else     tap_q <= tap_decode(pos_in);
    end

    // R1: exactly one tap switch closed
    assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot(tap_q));

    // R2: select follows position one cycle later
    assert_follow_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (tap_q == (TAP_ONE << $past(pos_in))));

endmodule

// File: rtl/wiper_step_counter.sv
module wiper_step_counter
    import wsc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [wsc_pkg::BANK_W-1:0]  dreg_bank,
    input  logic                        recall_go,
    input  logic                        xfer_go,
    input  logic [wsc_pkg::SEL_W-1:0]   xfer_sel,
    input  logic                        wr_go,
    input  logic [wsc_pkg::POS_W-1:0]   wr_val,
    input  logic                        step_arm,
    input  logic                        scl,
    input  logic                        sda,
    output logic [wsc_pkg::POS_W-1:0]   wiper_pos,
    output logic [wsc_pkg::TAPS-1:0]    tap_sel,
    output logic                        step_active
);
    bus_ev_t ev;
    logic    step_req;
    logic    step_up;
    pos_t    pos_q;
    tap_t    tap_q;
    logic    mode_q;

    wsc_bus_events u_events (
        .clk (clk),
        .rst (rst),
        .scl (scl),
        .sda (sda),
        .ev  (ev)
    );

    wsc_step_ctl u_step (
        .clk      (clk),
        .rst      (rst),
        .step_arm (step_arm),
        .sda      (sda),
        .ev       (ev),
        .mode_q   (mode_q),
        .step_req (step_req),
        .step_up  (step_up)
    );

    wsc_pos_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .dreg_bank (dreg_bank),
        .recall_go (recall_go),
        .xfer_go   (xfer_go),
        .xfer_sel  (xfer_sel),
        .wr_go     (wr_go),
        .wr_val    (wr_val),
        .step_req  (step_req),
        .step_up   (step_up),
        .pos_q     (pos_q)
    );

    wsc_tap_decode u_dec (
        .clk    (clk),
        .rst    (rst),
        .pos_in (pos_q),
        .tap_q  (tap_q)
    );

    assign wiper_pos   = pos_q;
    assign tap_sel     = tap_q;
    assign step_active = mode_q;

    // R10: reset state seen on the first cycle out of reset
    assert_reset_state_R10: assert property (@(posedge clk)
        $past(rst) |-> (wiper_pos == '0 && tap_sel == tap_t'(1) && !step_active));

endmodule

// File: tb/tb_wiper_step_counter.sv
module tb_wiper_step_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] dreg_bank = '0;
    logic        recall_go = 1'b0;
    logic        xfer_go = 1'b0;
    logic [1:0]  xfer_sel = '0;
    logic        wr_go = 1'b0;
    logic [5:0]  wr_val = '0;
    logic        step_arm = 1'b0;
    logic        scl = 1'b1;
    logic        sda = 1'b1;
    logic [5:0]  wiper_pos;
    logic [63:0] tap_sel;
    logic        step_active;

    int checks = 0;
    int errors = 0;
    logic [5:0] pos_m = '0;
    logic       mode_m = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    wiper_step_counter dut (
        .clk(clk), .rst(rst), .dreg_bank(dreg_bank), .recall_go(recall_go),
        .xfer_go(xfer_go), .xfer_sel(xfer_sel), .wr_go(wr_go), .wr_val(wr_val),
        .step_arm(step_arm), .scl(scl), .sda(sda), .wiper_pos(wiper_pos),
        .tap_sel(tap_sel), .step_active(step_active)
    );

    function automatic logic [5:0] m_step(logic [5:0] p, logic up);
        if (up) return (p == 6'h3F) ? p : p + 6'd1;
        return (p == 6'h00) ? p : p - 6'd1;
    endfunction

    function automatic logic [63:0] m_onehot(logic [5:0] p);
        logic [63:0] t;
        t = '0;
        t[p] = 1'b1;
        return t;
    endfunction

    function automatic logic [5:0] m_entry(logic [23:0] b, int i);
        return b[i*6 +: 6];
    endfunction

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // position now, decoded select one cycle later
    task automatic check_pos(string req);
        check(req, {58'd0, wiper_pos}, {58'd0, pos_m});
        cyc();
        check("R2", tap_sel, m_onehot(pos_m));
    endtask

    task automatic do_recall();
        recall_go = 1'b1; cyc(); recall_go = 1'b0;
        pos_m = m_entry(dreg_bank, 0);
    endtask

    task automatic do_xfer(logic [1:0] s);
        xfer_sel = s; xfer_go = 1'b1; cyc(); xfer_go = 1'b0;
        pos_m = m_entry(dreg_bank, int'(s));
    endtask

    task automatic do_write(logic [5:0] v);
        wr_val = v; wr_go = 1'b1; cyc(); wr_go = 1'b0;
        pos_m = v;
    endtask

    task automatic do_arm();
        step_arm = 1'b1; cyc(); step_arm = 1'b0;
        mode_m = 1'b1;
    endtask

    // from idle (both high) to clock low
    task automatic bus_start();
        sda = 1'b0; cyc();
        scl = 1'b0; cyc();
    endtask

    // from clock low to idle
    task automatic bus_stop();
        sda = 1'b0; cyc();
        scl = 1'b1; cyc();
        sda = 1'b1; cyc();
        mode_m = 1'b0;
    endtask

    task automatic pulse(logic d);
        sda = d; cyc();
        scl = 1'b1; cyc();
        cyc();
        scl = 1'b0; cyc();
        if (mode_m) pos_m = m_step(pos_m, d);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        dreg_bank = {6'd50, 6'd33, 6'd17, 6'd9};
        repeat (5) cyc();
        rst = 1'b0;
        // R10 reset state
        check("R10", {58'd0, wiper_pos}, 64'd0);
        check("R10", tap_sel, 64'd1);
        check("R10", {63'd0, step_active}, 64'd0);

        // R5 recall of entry 0
        do_recall(); check_pos("R5");
        // R6 each entry
        for (int i = 0; i < 4; i++) begin
            do_xfer(2'(i)); check_pos("R6");
        end
        // R7 write, and R1 both ends of the select
        do_write(6'h00); check_pos("R7");
        check("R1", tap_sel, 64'd1);
        do_write(6'h3F); check_pos("R7");
        check("R1", tap_sel, 64'h8000_0000_0000_0000);

        // R4 pulses before arming have no effect
        bus_start();
        pulse(1'b0); check_pos("R4");
        pulse(1'b0); check_pos("R4");
        do_arm();
        check("R12", {63'd0, step_active}, 64'd1);
        // R8 saturation at top, then run down
        pulse(1'b1); check_pos("R8");
        for (int i = 0; i < 5; i++) begin
            pulse(1'b0); check_pos("R3");
        end
        check("R3", {58'd0, wiper_pos}, 64'd58);
        do_write(6'd1);
        pulse(1'b0); check_pos("R3");
        pulse(1'b0); check_pos("R8");
        check("R8", {58'd0, wiper_pos}, 64'd0);
        pulse(1'b1); check_pos("R3");
        // R11 pulse with moving sda: no step
        sda = 1'b1; cyc();
        scl = 1'b1; cyc();
        sda = 1'b0; cyc();
        scl = 1'b0; cyc();
        check_pos("R11");
        // R9 write and step fall in the same cycle: write wins
        sda = 1'b1; cyc();
        scl = 1'b1; cyc();
        scl = 1'b0; wr_val = 6'd40; wr_go = 1'b1; cyc(); wr_go = 1'b0;
        pos_m = 6'd40;
        check_pos("R9");
        bus_stop();
        check("R12", {63'd0, step_active}, 64'd0);
        // R4 after stop, pulses ignored
        bus_start();
        pulse(1'b1); check_pos("R4");
        // R9 all loads together
        recall_go = 1'b1; xfer_go = 1'b1; xfer_sel = 2'd3; wr_go = 1'b1; wr_val = 6'd5; cyc();
        recall_go = 1'b0;
        pos_m = m_entry(dreg_bank, 0);
        check_pos("R9");
        wr_val = 6'd5; cyc();
        xfer_go = 1'b0; wr_go = 1'b0;
        pos_m = m_entry(dreg_bank, 3);
        check_pos("R9");

        // random sessions
        for (int s = 0; s < 12; s++) begin
            dreg_bank = 24'($urandom);
            do_arm();
            for (int k = 0; k < 40; k++) begin
                int op;
                op = int'($urandom_range(0, 9));
                if (op < 4)      begin pulse(1'b1); check_pos("R3"); end
                else if (op < 8) begin pulse(1'b0); check_pos("R3"); end
                else if (op < 9) begin do_xfer(2'($urandom)); check_pos("R6"); end
                else             begin do_write(6'($urandom)); check_pos("R7"); end
            end
            bus_stop();
            bus_start();
        end
        pulse(1'b1); check_pos("R4");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule